// File: doc/BRIEF.md
# Two-Wire Register Slave with 16-Bit Words

This block is the serial configuration port of a register-mapped peripheral. It watches the SCL and SDA lines of a two-wire bus and samples both on its own system clock. It finds start, repeated-start and stop conditions. When the first byte of a transfer carries its own device address, it takes part in the transfer. Two strap pins choose which of four device addresses it answers to. Registers are 16 bits wide behind an 8-bit register address. Every word travels as two bytes, high byte first, and the register pointer steps by one after each complete word.

The block does not hold the registers itself. It reaches an external register file through a plain port: an address, write data, a one-cycle write strobe, and read data that is returned combinationally for the address presented. SDA is driven as open drain: `sdaOe` high pulls the line low. Register 0xF0 is a byte window for masters that move only single bytes. A register's high byte is written or read on its own, and the matching low byte then follows through 0xF0.

The system clock must run at least 8 times faster than SCL. Clock stretching, 10-bit addressing, general call and multi-master arbitration are not supported.

Top module: `tw_reg_slave`

## Requirements
- R1: The 7-bit device address is {1,0,strapSel[1],1,strapSel[0],0,0}, which gives 0x48, 0x4C, 0x58 and 0x5C for straps 00, 01, 10 and 11 (address bytes 0x90/0x91, 0x98/0x99, 0xB0/0xB1, 0xB8/0xB9). Bit 0 of the address byte is 1 for a read. A matching address byte is acknowledged by SDA low during the ninth SCL high period.
- R2: On a non-matching address byte, SDA is not pulled low during the ninth clock, and the slave writes no register until the next start or stop.
- R3: In a write, the byte after the address byte sets the register pointer. The next two bytes are the high byte and then the low byte. After the low byte, exactly one one-cycle `regWe` pulse writes {high, low} to the pointer. Each of these bytes is acknowledged.
- R4: A write that ends after only the high byte produces no `regWe` pulse and leaves the register unchanged.
- R5: After each complete written word the pointer steps by one, so that consecutive words land in consecutive registers.
- R6: A read uses the pointer left by an earlier write phase. Data is shifted out high byte first, and the next register follows for as long as the master acknowledges. After a master NACK, SDA is released (`sdaOe` low).
- R7: After a write that ends with the high byte of register X, a one-byte write to register 0xF0 stores {that high byte, the new byte} into X.
- R8: After the high byte of register X has been read, a one-byte read of register 0xF0 returns the low byte of X.
- R9: A repeated start in the middle of a word discards the partial word: the register is not written, and address reception begins again.
- R10: `sdaOe` changes only while SCL is low. After reset, `sdaOe` and `regWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapSel | input | 2 | Strap pins selecting the device address |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |
| regAddr | output | 8 | Register file address (write address during a strobe) |
| regWdata | output | 16 | Register file write data |
| regWe | output | 1 | One-cycle register write strobe |
| regRdata | input | 16 | Register file read data for `regAddr` |

## Verification
SCL and SDA pass through two synchronizer flops and one edge flop, so `sdaOe` moves about three system cycles after the SCL falling edge that starts an acknowledge or data bit. The bench therefore samples the acknowledge and read bits in the middle of the following SCL high period, which is six cycles after SCL rises. `regWe` rises one cycle after the slave sees the falling edge that ends the eighth bit of a low byte. A monitor records each strobe, and every change of `sdaOe` while SCL is high, on the falling clock edge. Counts of writes and the logged address and data are compared only once the stop or the next transfer has finished, and the contents of each register are checked by reading them back over the bus.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEVACK, ST_REG, ST_REGACK,
    ST_WR, ST_WRACK, ST_RD, ST_RDACK, ST_SKIP
  } twState_t;

  // bus events seen on the system clock
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sclLvl;
    logic sdaLvl;
  } busEv_t;

  // control -> datapath strobes
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic setPtr;
    logic wrByte;
    logic loadTx;
    logic phase;     // 0: high byte of a word, 1: low byte
  } dpCmd_t;

  // R1: strap pins fill bits 4 and 2 of the 7-bit device address
  function automatic logic [6:0] devAddrOf(input logic [1:0] strap);
    return {2'b10, strap[1], 1'b1, strap[0], 2'b00};
  endfunction

endpackage

// File: rtl/tw_reg_sync.sv
module tw_reg_sync
  import tw_reg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output busEv_t ev
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD, sclS, sdaS;

  // reset to the idle bus level so that no start is seen at release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD    <= sclPipe[STAGES-1];
      sdaD    <= sdaPipe[STAGES-1];
    end
  end

  assign sclS = sclPipe[STAGES-1];
  assign sdaS = sdaPipe[STAGES-1];

  always_comb begin
    ev.sclLvl  = sclS;
    ev.sdaLvl  = sdaS;
    ev.sclRise = sclS & ~sclD;
    ev.sclFall = ~sclS & sclD;
    ev.start   = sclS & sclD & sdaD & ~sdaS;
    ev.stop    = sclS & sclD & ~sdaD & sdaS;
  end

endmodule

// File: rtl/tw_reg_ctrl.sv
module tw_reg_ctrl
  import tw_reg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [1:0]        strapSel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output dpCmd_t            cmd,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  twState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic             phase, isRead, mAck;
  logic             byteDone, devHit, busy;

  assign byteDone = ev.sclFall && (bitCnt == CNT_W'(BYTE_W));
  assign devHit   = (rxByte[BYTE_W-1:1] == devAddrOf(strapSel));
  assign busy     = !ev.start && !ev.stop;

  always_comb begin
    cmd       = '0;
    cmd.phase = phase;
    if (busy) begin
      case (state)
        ST_DEV:    cmd.shiftIn  = ev.sclRise;
        ST_REG: begin
          cmd.shiftIn = ev.sclRise;
          cmd.setPtr  = byteDone;
        end
        ST_WR: begin
          cmd.shiftIn = ev.sclRise;
          cmd.wrByte  = byteDone;
        end
        ST_DEVACK: cmd.loadTx   = ev.sclFall && isRead;
        ST_RD:     cmd.shiftOut = ev.sclFall && (bitCnt != CNT_W'(BYTE_W));
        ST_RDACK:  cmd.loadTx   = ev.sclFall && mAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
      isRead <= 1'b0;
      mAck   <= 1'b0;
    end else if (ev.stop) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
    end else if (ev.start) begin
      // R9: any start drops a partial word and restarts address reception
      state  <= ST_DEV;
      bitCnt <= '0;
      phase  <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_REG, ST_WR: begin
          if (ev.sclRise) bitCnt <= bitCnt + 1'b1;
          else if (byteDone) begin
            bitCnt <= '0;
            if (state == ST_DEV) begin
              if (devHit) begin
                state  <= ST_DEVACK;
                isRead <= rxByte[0];
              end else begin
                state  <= ST_SKIP;      // R2
              end
            end else if (state == ST_REG) begin
              state <= ST_REGACK;
              phase <= 1'b0;
            end else begin
              state <= ST_WRACK;
              phase <= ~phase;
            end
          end
        end
        ST_DEVACK: if (ev.sclFall) begin
          if (isRead) begin
            state <= ST_RD;
            phase <= ~phase;
          end else begin
            state <= ST_REG;
          end
        end
        ST_REGACK, ST_WRACK: if (ev.sclFall) state <= ST_WR;
        ST_RD: begin
          if (ev.sclRise) bitCnt <= bitCnt + 1'b1;
          else if (byteDone) begin
            bitCnt <= '0;
            state  <= ST_RDACK;
          end
        end
        ST_RDACK: begin
          if (ev.sclRise) mAck <= ~ev.sdaLvl;
          else if (ev.sclFall) begin
            if (mAck) begin
              state <= ST_RD;
              phase <= ~phase;
            end else begin
              state <= ST_SKIP;         // R6: master NACK ends the stream
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (state == ST_DEVACK) || (state == ST_REGACK) ||
                 (state == ST_WRACK) || ((state == ST_RD) && !txBit);

  // R10: the open-drain enable moves only while SCL is low
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !ev.sclLvl);

  // R2: an unaddressed slave never drives the line
  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaOe);

  // R3: the acknowledge slot opens only on the falling edge after a byte
  assert_ack_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WRACK) && ($past(state) == ST_WR)) |-> $past(ev.sclFall));

  // R3: the bit counter never runs past one byte
  assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/tw_reg_dp.sv
module tw_reg_dp
  import tw_reg_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 16,
  parameter logic [7:0]  WIN_ADDR = 8'hF0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  input  logic                  sdaLvl,
  output logic [DATA_W/2-1:0]   rxByte,
  output logic                  txBit,
  output logic [ADDR_W-1:0]     regAddr,
  output logic [DATA_W-1:0]     regWdata,
  output logic                  regWe,
  input  logic [DATA_W-1:0]     regRdata
);
  localparam int BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] rxShift, txShift, hiByte, loByte;
  logic [ADDR_W-1:0] ptr, hiAddr, wrAddr;
  logic [DATA_W-1:0] wData;
  logic              we, winHit;

  assign winHit = (ptr == ADDR_W'(WIN_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      hiByte  <= '0;
      loByte  <= '0;
      ptr     <= '0;
      hiAddr  <= '0;
      wrAddr  <= '0;
      wData   <= '0;
      we      <= 1'b0;
    end else begin
      we <= 1'b0;
      if (cmd.shiftIn)  rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};
      if (cmd.shiftOut) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (cmd.setPtr)   ptr     <= ADDR_W'(rxShift);
      if (cmd.wrByte) begin
        if (winHit) begin
          // R7: window byte completes the word held from an earlier high byte
          we     <= 1'b1;
          wrAddr <= hiAddr;
          wData  <= {hiByte, rxShift};
        end else if (!cmd.phase) begin
          // R4: high byte is only held, nothing is written yet
          hiByte <= rxShift;
          hiAddr <= ptr;
        end else begin
          // R3, R5: full word committed, pointer steps
          we     <= 1'b1;
          wrAddr <= ptr;
          wData  <= {hiByte, rxShift};
          ptr    <= ptr + 1'b1;
        end
      end
      if (cmd.loadTx) begin
        if (winHit) begin
          txShift <= loByte;                    // R8
        end else if (!cmd.phase) begin
          txShift <= regRdata[DATA_W-1:BYTE_W];
          loByte  <= regRdata[BYTE_W-1:0];
          hiAddr  <= ptr;
        end else begin
          txShift <= loByte;
          ptr     <= ptr + 1'b1;                // R6
        end
      end
    end
  end

  assign rxByte   = rxShift;
  assign txBit    = txShift[BYTE_W-1];
  assign regWe    = we;
  assign regWdata = wData;
  assign regAddr  = we ? wrAddr : ptr;

  // R3: each write strobe lasts a single cycle
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R5: the pointer is either loaded from the bus or steps by one
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ptr != $past(ptr)) |-> ($past(cmd.setPtr) || (ptr == $past(ptr) + 1'b1)));

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_reg_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 16,
  parameter logic [7:0] WIN_ADDR    = 8'hF0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapSel,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);
  localparam int BYTE_W = DATA_W / 2;

  busEv_t            ev;
  dpCmd_t            cmd;
  logic [BYTE_W-1:0] rxByte;
  logic              txBit;

  tw_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ev(ev)
  );

  tw_reg_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .strapSel(strapSel),
    .rxByte(rxByte), .txBit(txBit), .cmd(cmd), .sdaOe(sdaOe)
  );

  tw_reg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_ADDR(WIN_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaLvl(ev.sdaLvl),
    .rxByte(rxByte), .txBit(txBit), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

endmodule

// File: tb/tw_reg_slave_bench.sv
module tw_reg_slave_bench;
  localparam int H = 12;   // system cycles per SCL half period

  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, sclM, sdaM, sdaBus, sdaOe, regWe;
  logic [1:0]  strap;
  logic [7:0]  regAddr;
  logic [15:0] regWdata, regRdata;

  logic [15:0] mem    [256];
  logic [15:0] expMem [256];
  logic [15:0] wbuf [4];
  logic [15:0] rbuf [4];

  int vecs = 0, bad = 0, wrCount = 0, oeFlips = 0;
  logic [7:0]  lastWa;
  logic [15:0] lastWd;
  logic        oePrev = 1'b0, oeAfterNack;

  assign sdaBus   = sdaM & ~sdaOe;
  assign regRdata = mem[regAddr];

  tw_reg_slave u_tw_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapSel(strap),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata)
  );

  // register file model and write / line monitor
  always @(negedge clk) begin
    if (regWe) begin
      mem[regAddr] = regWdata;
      wrCount++;
      lastWa = regAddr;
      lastWd = regWdata;
    end
    if (rstN && (sdaOe !== oePrev) && sclM) oeFlips++;
    oePrev = sdaOe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input logic [1:0] s, input logic rd);
    return {2'b10, s[1], 1'b1, s[0], 2'b00, rd};
  endfunction

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitX(input logic b, output logic r);
    hw(H/2); sdaM = b; hw(H/2); sclM = 1'b1; hw(H/2); r = sdaBus; hw(H/2); sclM = 1'b0;
  endtask

  task automatic startC;
    if (sclM) begin
      sdaM = 1'b1; hw(H); sdaM = 1'b0; hw(H); sclM = 1'b0;
    end else begin
      hw(H/2); sdaM = 1'b1; hw(H/2); sclM = 1'b1; hw(H); sdaM = 1'b0; hw(H); sclM = 1'b0;
    end
  endtask

  task automatic stopC;
    hw(H/2); sdaM = 1'b0; hw(H/2); sclM = 1'b1; hw(H); sdaM = 1'b1; hw(2*H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitX(b[i], r);
    bitX(1'b1, r);
    ack = ~r;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitX(1'b1, r);
      b[i] = r;
    end
    bitX(~giveAck, r);
  endtask

  task automatic wrSeq(input logic [7:0] a, input int n, output logic devAck);
    logic k;
    startC;
    sendByte(devByte(strap, 1'b0), devAck);
    sendByte(a, k);
    for (int w = 0; w < n; w++) begin
      sendByte(wbuf[w][15:8], k);
      sendByte(wbuf[w][7:0], k);
      expMem[8'(a + w)] = wbuf[w];
    end
    stopC;
  endtask

  task automatic rdSeq(input logic [7:0] a, input int n);
    logic k;
    logic [7:0] hi, lo;
    startC;
    sendByte(devByte(strap, 1'b0), k);
    sendByte(a, k);
    startC;
    sendByte(devByte(strap, 1'b1), k);
    for (int w = 0; w < n; w++) begin
      recvByte(1'b1, hi);
      recvByte(w != n - 1, lo);
      rbuf[w] = {hi, lo};
    end
    hw(4);
    oeAfterNack = sdaOe;
    stopC;
  endtask

  initial begin
    logic ack, k;
    logic [7:0] b8;
    int cnt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0123) ^ 16'hA55A;
      expMem[i] = 16'(i * 16'h0123) ^ 16'hA55A;
    end
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; strap = 2'b00;
    hw(6);
    chk("R10 reset sdaOe", 32'(sdaOe), 32'd0);
    chk("R10 reset regWe", 32'(regWe), 32'd0);
    rstN = 1'b1;
    hw(6);

    // R1: every strap setting, write then read back
    for (int s = 0; s < 4; s++) begin
      logic [7:0] a;
      strap = 2'(s);
      hw(4);
      a = 8'(8'h10 + s * 8'h11);
      wbuf[0] = 16'($urandom);
      wrSeq(a, 1, ack);
      chk("R1 device ack", 32'(ack), 32'd1);
      chk("R3 strobe address", 32'(lastWa), 32'(a));
      chk("R3 strobe data", 32'(lastWd), 32'(wbuf[0]));
      rdSeq(a, 1);
      chk("R1 readback", 32'(rbuf[0]), 32'(expMem[a]));
    end

    // R2: wrong device address
    strap = 2'b11;
    hw(4);
    cnt = wrCount;
    startC;
    sendByte(devByte(2'b00, 1'b0), ack);
    chk("R2 no ack", 32'(ack), 32'd0);
    sendByte(8'h20, k);
    sendByte(8'h12, k);
    sendByte(8'h34, k);
    stopC;
    chk("R2 no write", 32'(wrCount), 32'(cnt));
    rdSeq(8'h20, 1);
    chk("R2 register kept", 32'(rbuf[0]), 32'(expMem[8'h20]));

    // R5 / R6: three-word burst
    cnt = wrCount;
    wbuf[0] = 16'h1357; wbuf[1] = 16'h2468; wbuf[2] = 16'hFEDC;
    wrSeq(8'h30, 3, ack);
    chk("R5 three strobes", 32'(wrCount), 32'(cnt + 3));
    rdSeq(8'h30, 3);
    for (int w = 0; w < 3; w++)
      chk("R6 burst read", 32'(rbuf[w]), 32'(expMem[8'(8'h30 + w)]));
    chk("R6 released after nack", 32'(oeAfterNack), 32'd0);

    // R4: high byte only
    cnt = wrCount;
    startC;
    sendByte(devByte(strap, 1'b0), k);
    sendByte(8'h41, k);
    sendByte(8'h9C, ack);
    chk("R3 data byte ack", 32'(ack), 32'd1);
    stopC;
    chk("R4 no strobe", 32'(wrCount), 32'(cnt));
    rdSeq(8'h41, 1);
    chk("R4 register kept", 32'(rbuf[0]), 32'(expMem[8'h41]));

    // R7: low byte through the window
    startC;
    sendByte(devByte(strap, 1'b0), k);
    sendByte(8'hF0, k);
    sendByte(8'h37, k);
    stopC;
    expMem[8'h41] = 16'h9C37;
    chk("R7 window address", 32'(lastWa), 32'h41);
    chk("R7 window data", 32'(lastWd), 32'h9C37);

    // R8: high byte read, then low byte through the window
    startC;
    sendByte(devByte(strap, 1'b0), k);
    sendByte(8'h52, k);
    startC;
    sendByte(devByte(strap, 1'b1), k);
    recvByte(1'b0, b8);
    stopC;
    chk("R8 high byte", 32'(b8), 32'(expMem[8'h52][15:8]));
    startC;
    sendByte(devByte(strap, 1'b0), k);
    sendByte(8'hF0, k);
    startC;
    sendByte(devByte(strap, 1'b1), k);
    recvByte(1'b0, b8);
    stopC;
    chk("R8 window low byte", 32'(b8), 32'(expMem[8'h52][7:0]));

    // R9: repeated start mid-word
    cnt = wrCount;
    startC;
    sendByte(devByte(strap, 1'b0), k);
    sendByte(8'h63, k);
    sendByte(8'hEE, k);
    startC;
    sendByte(devByte(strap, 1'b0), ack);
    chk("R9 address after restart", 32'(ack), 32'd1);
    sendByte(8'h64, k);
    sendByte(8'hAB, k);
    sendByte(8'hCD, k);
    stopC;
    expMem[8'h64] = 16'hABCD;
    chk("R9 single strobe", 32'(wrCount), 32'(cnt + 1));
    chk("R9 strobe address", 32'(lastWa), 32'h64);
    rdSeq(8'h63, 1);
    chk("R9 partial dropped", 32'(rbuf[0]), 32'(expMem[8'h63]));

    // random bursts on random straps
    for (int it = 0; it < 16; it++) begin
      logic [7:0] a;
      int n;
      strap = 2'($urandom_range(0, 3));
      hw(4);
      a = 8'($urandom_range(0, 8'hE0));
      n = $urandom_range(1, 3);
      for (int w = 0; w < n; w++) wbuf[w] = 16'($urandom);
      wrSeq(a, n, ack);
      chk("R1 random ack", 32'(ack), 32'd1);
      rdSeq(a, n);
      for (int w = 0; w < n; w++)
        chk("R5 random readback", 32'(rbuf[w]), 32'(expMem[8'(a + w)]));
    end

    chk("R10 sda changes only with scl low", 32'(oeFlips), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    vecs++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule